// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Hysteresis

This block predicts the next fetch address for an instruction. It keeps a small direct-indexed table. Each entry stores a predicted next address and a two-bit confidence state. The front end presents an instruction address on the lookup port. The table entry selected by the low address bits returns its stored next address as the prediction, together with its confidence state. No tag is compared, so addresses that share low bits share an entry.

When a branch resolves, the back end reports three things on the update port: the branch address, the real next address, and whether the earlier prediction was right. A right prediction strengthens the entry toward its current direction. A wrong prediction first only weakens the entry. The stored target is replaced only when the entry was already weak, and the state then jumps to the weak state of the other direction. A build-time parameter selects a simpler one-bit policy, in which every wrong prediction replaces the stored target.

Top module: `btb_hyst_predictor`

## Requirements
- R1: After reset, entry i predicts address i+1 and holds the state weakly-not-taken. State encoding: 2'b00 strongly-not-taken, 2'b01 weakly-not-taken, 2'b10 weakly-taken, 2'b11 strongly-taken. Bit 1 is the direction, and the state is strong when both bits are equal.
- R2: The entry index is the low 4 bits of the address. The lookup returns that entry's target and state in the same cycle, whatever the upper address bits are.
- R3: An update marked correct moves the entry to the strong state of its current direction and leaves the target unchanged.
- R4: With the two-bit policy, an update marked wrong on a strong entry moves it to the weak state of the same direction and keeps the target.
- R5: An update marked wrong on a weak entry writes the reported next address as the target and moves the entry to the weak state of the opposite direction.
- R6: With the one-bit policy, every update marked wrong writes the reported next address as the target. The state still moves to the weak state of the opposite direction.
- R7: When an update and a lookup hit the same index in one cycle, the lookup returns the old contents. The new contents are visible from the next clock edge.
- R8: While upd_valid is low, no entry changes. An update to one index leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 16 | Lookup instruction address |
| lk_target | output | 16 | Predicted next address |
| lk_state | output | 2 | Confidence state of the looked-up entry |
| upd_valid | input | 1 | Update request |
| upd_addr | input | 16 | Address of the resolved branch |
| upd_next | input | 16 | Actual next address |
| upd_correct | input | 1 | Earlier prediction was right |

## Verification
On every update cycle, the assertions check the state transition chosen for the entry. They relate the old state read from storage to the new state and to the retarget event raised by the update logic. This covers strengthening, weakening and the weak-miss flip, plus the one-bit overwrite rule. They also check that nothing is written and no lookup result moves while no update is presented. The bench scenarios are the only checks that show the reset contents of all sixteen entries and the index aliasing of upper address bits. They also show that the new target is the reported address, and that a same-cycle lookup returns old data and then new data.

// File: rtl/btb_hyst_pkg.sv
package btb_hyst_pkg;

  typedef enum logic [1:0] {
    CONF_SNT = 2'b00,
    CONF_WNT = 2'b01,
    CONF_WT  = 2'b10,
    CONF_ST  = 2'b11
  } conf_e;

  localparam conf_e CONF_RESET = CONF_WNT;

  function automatic logic conf_strong(input conf_e s);
    return s[1] == s[0];
  endfunction

  function automatic logic conf_dir(input conf_e s);
    return s[1];
  endfunction

  // target replaced: wrong prediction while weak, or any miss in one-bit policy
  function automatic logic conf_retarget(input conf_e s, input logic correct,
                                         input logic one_bit);
    return !correct && (one_bit || !conf_strong(s));
  endfunction

  function automatic conf_e conf_next(input conf_e s, input logic correct,
                                      input logic one_bit);
    conf_e r;
    if (correct)
      r = conf_dir(s) ? CONF_ST : CONF_SNT;
    else if (conf_retarget(s, correct, one_bit))
      r = conf_dir(s) ? CONF_WNT : CONF_WT;
    else
      r = conf_dir(s) ? CONF_WT : CONF_WNT;
    return r;
  endfunction

endpackage

// File: rtl/btb_entry_store.sv
module btb_entry_store
  import btb_hyst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic              wr_tgt_en,
  input  conf_e             wr_state,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [ADDR_W-1:0] rd_a_tgt,
  output conf_e             rd_a_state,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output conf_e             rd_b_state
);

  logic [ADDR_W-1:0] tgt_q [ENTRIES];
  conf_e             st_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [ADDR_W-1:0] FALL_THRU = ADDR_W'(g + 1);
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_q[g] <= FALL_THRU;
        st_q[g]  <= CONF_RESET;
      end else if (hit) begin
        st_q[g] <= wr_state;
        if (wr_tgt_en) tgt_q[g] <= wr_tgt;
      end
    end
  end

  assign rd_a_tgt   = tgt_q[rd_a_idx];
  assign rd_a_state = st_q[rd_a_idx];
  assign rd_b_state = st_q[rd_b_idx];

endmodule

// File: rtl/btb_conf_update.sv
module btb_conf_update
  import btb_hyst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic              upd_valid,
  input  logic              upd_correct,
  input  logic [ADDR_W-1:0] upd_next,
  input  conf_e             old_state,
  output logic              wr_en,
  output logic              retarget,
  output conf_e             new_state,
  output logic [ADDR_W-1:0] new_tgt
);

  always_comb begin
    wr_en     = upd_valid;
    retarget  = upd_valid && conf_retarget(old_state, upd_correct, ONE_BIT);
    new_state = conf_next(old_state, upd_correct, ONE_BIT);
    new_tgt   = upd_next;
  end

endmodule

// File: rtl/btb_hyst_predictor.sv
module btb_hyst_predictor
  import btb_hyst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 16,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [ADDR_W-1:0] lk_target,
  output logic [1:0]        lk_state,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_next,
  input  logic              upd_correct
);

  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0]  lk_idx, upd_idx;
  conf_e             lk_conf, upd_old_state, upd_new_state;
  logic              tbl_we, upd_retarget;
  logic [ADDR_W-1:0] upd_new_tgt;

  assign lk_idx  = index_of(lk_addr);
  assign upd_idx = index_of(upd_addr);

  btb_conf_update #(.ADDR_W(ADDR_W), .ONE_BIT(ONE_BIT)) upd_i (
    .upd_valid  (upd_valid),
    .upd_correct(upd_correct),
    .upd_next   (upd_next),
    .old_state  (upd_old_state),
    .wr_en      (tbl_we),
    .retarget   (upd_retarget),
    .new_state  (upd_new_state),
    .new_tgt    (upd_new_tgt)
  );

  btb_entry_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (upd_idx),
    .wr_tgt    (upd_new_tgt),
    .wr_tgt_en (upd_retarget),
    .wr_state  (upd_new_state),
    .rd_a_idx  (lk_idx),
    .rd_a_tgt  (lk_target),
    .rd_a_state(lk_conf),
    .rd_b_idx  (upd_idx),
    .rd_b_state(upd_old_state)
  );

  assign lk_state = lk_conf;

endmodule

// File: rtl/btb_hyst_checker.sv
module btb_hyst_checker
  import btb_hyst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit ONE_BIT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_addr,
  input logic [ADDR_W-1:0] lk_target,
  input logic [1:0]        lk_state,
  input logic              upd_valid,
  input logic              upd_correct,
  input logic              tbl_we,
  input logic              upd_retarget,
  input conf_e             upd_old_state,
  input conf_e             upd_new_state
);

  p_correct_strong_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_correct) |->
      (conf_strong(upd_new_state) && conf_dir(upd_new_state) == conf_dir(upd_old_state)
       && !upd_retarget));

  p_strong_miss_weakens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ONE_BIT && upd_valid && !upd_correct && conf_strong(upd_old_state)) |->
      (!conf_strong(upd_new_state) && conf_dir(upd_new_state) == conf_dir(upd_old_state)
       && !upd_retarget));

  p_weak_miss_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_correct && !conf_strong(upd_old_state)) |->
      (upd_retarget && !conf_strong(upd_new_state)
       && conf_dir(upd_new_state) != conf_dir(upd_old_state)));

  p_onebit_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ONE_BIT && upd_valid && !upd_correct) |-> upd_retarget);

  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (!tbl_we && !upd_retarget));

  p_idle_lookup_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!upd_valid) && $stable(lk_addr)) |-> ($stable(lk_target) && $stable(lk_state)));

endmodule

bind btb_hyst_predictor btb_hyst_checker #(.ADDR_W(ADDR_W), .ONE_BIT(ONE_BIT)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_addr      (lk_addr),
  .lk_target    (lk_target),
  .lk_state     (lk_state),
  .upd_valid    (upd_valid),
  .upd_correct  (upd_correct),
  .tbl_we       (tbl_we),
  .upd_retarget (upd_retarget),
  .upd_old_state(upd_old_state),
  .upd_new_state(upd_new_state)
);

// File: tb/btb_hyst_predictor_tb.sv
`timescale 1ns/1ps
module btb_hyst_predictor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lk_addr, upd_addr, upd_next;
  logic        upd_valid, upd_correct;
  logic [15:0] tgt2, tgt1;
  logic [1:0]  st2, st1;

  int checks = 0;
  int fails  = 0;

  // reference model: index 0 = two-bit policy, index 1 = one-bit policy
  logic [15:0] m_tgt [2][16];
  logic [1:0]  m_st  [2][16];

  always #2.5 clk = ~clk;

  btb_hyst_predictor #(.ONE_BIT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_target(tgt2), .lk_state(st2),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_next(upd_next),
    .upd_correct(upd_correct));

  btb_hyst_predictor #(.ONE_BIT(1'b1)) dut_one_i (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_target(tgt1), .lk_state(st1),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_next(upd_next),
    .upd_correct(upd_correct));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model written from the transition list, not from the design's functions
  task automatic model_apply(input int mode, input int idx, input logic [15:0] nxt,
                             input logic ok);
    logic [1:0] s;
    s = m_st[mode][idx];
    case ({ok, s})
      3'b100, 3'b101: m_st[mode][idx] = 2'b00;
      3'b110, 3'b111: m_st[mode][idx] = 2'b11;
      3'b001: begin m_st[mode][idx] = 2'b10; m_tgt[mode][idx] = nxt; end
      3'b010: begin m_st[mode][idx] = 2'b01; m_tgt[mode][idx] = nxt; end
      3'b000: begin
        m_st[mode][idx] = (mode == 1) ? 2'b10 : 2'b01;
        if (mode == 1) m_tgt[mode][idx] = nxt;
      end
      default: begin
        m_st[mode][idx] = (mode == 1) ? 2'b01 : 2'b10;
        if (mode == 1) m_tgt[mode][idx] = nxt;
      end
    endcase
  endtask

  task automatic look(input string req, input logic [15:0] addr);
    @(negedge clk);
    lk_addr = addr;
    #1;
    chk({req, " two-bit target"}, tgt2, m_tgt[0][addr[3:0]]);
    chk({req, " two-bit state"}, {14'd0, st2}, {14'd0, m_st[0][addr[3:0]]});
    chk({req, " one-bit target"}, tgt1, m_tgt[1][addr[3:0]]);
    chk({req, " one-bit state"}, {14'd0, st1}, {14'd0, m_st[1][addr[3:0]]});
  endtask

  task automatic update(input logic [15:0] a, input logic [15:0] n, input logic ok);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_next = n; upd_correct = ok;
    @(posedge clk);
    #0.1;
    model_apply(0, a[3:0], n, ok);
    model_apply(1, a[3:0], n, ok);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset_r1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      lk_addr = 16'(i);
      #1;
      chk("R1 reset target", tgt2, 16'(i + 1));
      chk("R1 reset state", {14'd0, st2}, 16'h0001);
      chk("R1 reset target one-bit", tgt1, 16'(i + 1));
    end
  endtask

  task automatic t_weak_miss_r5;
    update(16'h1234, 16'h5678, 1'b0);
    look("R5 weak miss retarget", 16'h0004);
    chk("R5 explicit target", tgt2, 16'h5678);
    chk("R5 explicit state", {14'd0, st2}, 16'h0002);
    look("R2 alias upper bits", 16'hFFF4);
    look("R8 neighbour untouched", 16'h0005);
  endtask

  task automatic t_correct_r3;
    update(16'h0004, 16'h5678, 1'b1);
    look("R3 correct strengthens", 16'h0004);
    chk("R3 explicit state", {14'd0, st2}, 16'h0003);
    update(16'h0009, 16'h000A, 1'b1);
    look("R3 correct not-taken", 16'h0009);
    chk("R3 explicit nt state", {14'd0, st2}, 16'h0000);
  endtask

  task automatic t_strong_miss_r4_r6;
    update(16'h0004, 16'h9ABC, 1'b0);
    look("R4 strong miss keeps target", 16'h0004);
    chk("R4 explicit target", tgt2, 16'h5678);
    chk("R4 explicit state", {14'd0, st2}, 16'h0002);
    chk("R6 one-bit overwrites", tgt1, 16'h9ABC);
    chk("R6 one-bit state", {14'd0, st1}, 16'h0001);
    update(16'h0004, 16'h1235, 1'b0);
    look("R5 second weak miss", 16'h0004);
    chk("R5 explicit flip to nt", {14'd0, st2}, 16'h0001);
    chk("R5 explicit new target", tgt2, 16'h1235);
  endtask

  task automatic t_same_cycle_r7;
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 16'h0007; upd_next = 16'hBEEF; upd_correct = 1'b0;
    lk_addr = 16'h0107;
    #1;
    chk("R7 same-cycle old target", tgt2, 16'h0008);
    chk("R7 same-cycle old state", {14'd0, st2}, 16'h0001);
    @(posedge clk);
    #0.1;
    model_apply(0, 7, 16'hBEEF, 1'b0);
    model_apply(1, 7, 16'hBEEF, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R7 new target next cycle", tgt2, 16'hBEEF);
    look("R7 new contents", 16'h0007);
  endtask

  task automatic t_idle_r8;
    @(negedge clk);
    upd_valid = 1'b0; upd_addr = 16'h0004; upd_next = 16'h0F0F; upd_correct = 1'b0;
    repeat (3) @(posedge clk);
    look("R8 idle no change", 16'h0004);
    for (int i = 0; i < 16; i++) look("R8 full sweep", 16'(i));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++) begin
        m_tgt[m][i] = 16'(i + 1);
        m_st[m][i]  = 2'b01;
      end
    rst_n = 1'b0; lk_addr = '0; upd_addr = '0; upd_next = '0;
    upd_valid = 1'b0; upd_correct = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_weak_miss_r5();
    t_correct_r3();
    t_strong_miss_r4_r6();
    t_same_cycle_r7();
    t_idle_r8();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule